// File: doc/BRIEF.md
# Configuration Status Register with Sticky Event Flags

This block is the 16-bit status word of a PCI configuration header. Single-cycle strobes from the bus interface logic set its event flags. Each flag then holds its value until software clears it. The events are:

- a detected data parity error
- a signalled system error
- a received master abort
- a received target abort
- a signalled target abort
- a master data parity error

Two access paths lead to the word: a local processor register port and a PCI configuration-space port. Both paths return the same value. Either path can clear flags by writing ones. A write can never set a bit.

The capability fields are read-only constants fixed by parameters: decode timing, fast back-to-back capable, 66 MHz capable and capability list present. A target-only build ties the signalled-target-abort flag to zero. All remaining positions are reserved and always read zero.

Top module: `pci_cfg_status`

## Requirements
- R1: While `rst_n` is low, and after it is released, every event flag reads 0 and the read value equals the constant capability pattern.
- R2: `cpu_rd_data` and `cfg_rd_data` always carry the same value.
- R3: A write from either port clears exactly those event flags whose bit in the write data is 1. Flags written with 0 keep their value. For example, writing 16'h4000 clears only bit 14.
- R4: A write never sets any bit. Writing ones to a clear flag, to a constant field or to a reserved bit leaves that bit unchanged.
- R5: Reserved bits 6 and 3:0 read 0. Bits 10:9 read `DEVSEL_TIMING`, bit 7 reads `FAST_B2B`, bit 5 reads `CAP_66MHZ` and bit 4 reads `CAP_LIST`.
- R6: A pulse on `ev_perr_detect` sets bit 15 on the next clock edge, whatever the value of `parity_resp_en`.
- R7: A pulse on `ev_master_dperr` sets bit 8 only when `parity_resp_en` is 1 in the same cycle. Otherwise it has no effect.
- R8: Pulses on `ev_serr_sent`, `ev_mabort_rcvd`, `ev_tabort_rcvd` and `ev_tabort_sent` set bits 14, 13, 12 and 11. Each flag stays at 1 until it is cleared.
- R9: When a set strobe and a clearing write reach the same flag in the same cycle, the flag ends up at 1.
- R10: When both ports write in the same cycle, the flags named by either write data word are cleared.
- R11: With `TARGET_ONLY` = 1, bit 11 reads 0 even after `ev_tabort_sent` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| parity_resp_en | input | 1 | Parity error response enable from the command word |
| ev_perr_detect | input | 1 | Strobe: parity error seen in received data |
| ev_serr_sent | input | 1 | Strobe: system error driven |
| ev_mabort_rcvd | input | 1 | Strobe: master abort ended a transaction |
| ev_tabort_rcvd | input | 1 | Strobe: target abort received as master |
| ev_tabort_sent | input | 1 | Strobe: target abort signalled as target |
| ev_master_dperr | input | 1 | Strobe: data parity error while master |
| cpu_wr_en | input | 1 | Local port write enable |
| cpu_wr_data | input | 16 | Local port write data (ones clear) |
| cpu_rd_data | output | 16 | Local port read data |
| cfg_wr_en | input | 1 | Configuration port write enable |
| cfg_wr_data | input | 16 | Configuration port write data (ones clear) |
| cfg_rd_data | output | 16 | Configuration port read data |

## Verification
A hardware set strobe and a software clear can land on the same flag in the same clock cycle, and the register must let the set win. The bench sweeps every combination of the six strobes. It pairs each combination with computed clear masks from one port, from the other port, or from both at once, and with parity response on and off. Each result is judged against a bench model: flags first lose the ORed clear mask, then gain the gated sets. Directed steps aim a clear and a set at the same flag in the same cycle.

// File: rtl/pci_stat_pkg.sv
package pci_stat_pkg;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned NUM_EV = 6;

  // Flag index to bit position; index 4 is the signalled target abort.
  localparam int unsigned EV_POS [NUM_EV] = '{15, 14, 13, 12, 11, 8};
  localparam int unsigned IDX_TABORT_SENT = 4;

  localparam int unsigned POS_DEVSEL_LO = 9;
  localparam int unsigned POS_FB2B      = 7;
  localparam int unsigned POS_66MHZ     = 5;
  localparam int unsigned POS_CAPLIST   = 4;

  localparam logic [STAT_W-1:0] RSVD_MASK = 16'h004F;

  function automatic logic [STAT_W-1:0] const_word(input logic [1:0] devsel,
                                                   input logic fb2b,
                                                   input logic m66,
                                                   input logic caplist);
    logic [STAT_W-1:0] w;
    w = '0;
    w[POS_DEVSEL_LO +: 2] = devsel;
    w[POS_FB2B]           = fb2b;
    w[POS_66MHZ]          = m66;
    w[POS_CAPLIST]        = caplist;
    return w;
  endfunction
endpackage

// File: rtl/pcs_clear_merge.sv
module pcs_clear_merge
  import pci_stat_pkg::*;
(
  input  logic              cpu_we,
  input  logic [STAT_W-1:0] cpu_wd,
  input  logic              cfg_we,
  input  logic [STAT_W-1:0] cfg_wd,
  output logic [NUM_EV-1:0] clr_flag
);
  logic [STAT_W-1:0] clr_word;

  always_comb begin
    clr_word = (cpu_we ? cpu_wd : '0) | (cfg_we ? cfg_wd : '0);
    for (int g = 0; g < NUM_EV; g++) begin
      clr_flag[g] = clr_word[EV_POS[g]];
    end
  end
endmodule

// File: rtl/pcs_sticky_bit.sv
module pcs_sticky_bit #(
  parameter bit TIE_ZERO = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  generate
    if (TIE_ZERO) begin : g_tied
      assign q_o = 1'b0;
    end else begin : g_flag
      logic q_r, q_d, q_en;

      always_comb begin
        q_en = set_i | clr_i;
        q_d  = set_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_r <= 1'b0;
        else if (q_en) q_r <= q_d;
      end

      assign q_o = q_r;

      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
      p_clear_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && q_o) |=> q_o);
      p_no_write_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !q_o) |=> !q_o);
    end
  endgenerate
endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
  import pci_stat_pkg::*;
#(
  parameter logic [1:0] DEVSEL_TIMING = 2'b01,
  parameter bit         FAST_B2B      = 1'b1,
  parameter bit         CAP_66MHZ     = 1'b0,
  parameter bit         CAP_LIST      = 1'b1,
  parameter bit         TARGET_ONLY   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        parity_resp_en,
  input  logic        ev_perr_detect,
  input  logic        ev_serr_sent,
  input  logic        ev_mabort_rcvd,
  input  logic        ev_tabort_rcvd,
  input  logic        ev_tabort_sent,
  input  logic        ev_master_dperr,
  input  logic        cpu_wr_en,
  input  logic [15:0] cpu_wr_data,
  output logic [15:0] cpu_rd_data,
  input  logic        cfg_wr_en,
  input  logic [15:0] cfg_wr_data,
  output logic [15:0] cfg_rd_data
);
  localparam logic [STAT_W-1:0] CONST_W =
    const_word(DEVSEL_TIMING, FAST_B2B, CAP_66MHZ, CAP_LIST);

  logic [NUM_EV-1:0] set_flag, clr_flag, flag_q;
  logic [STAT_W-1:0] status;

  // Master data parity error is recorded only under parity response.
  always_comb begin
    set_flag = {ev_master_dperr & parity_resp_en, ev_tabort_sent,
                ev_tabort_rcvd, ev_mabort_rcvd, ev_serr_sent, ev_perr_detect};
  end

  pcs_clear_merge u_clr (
    .cpu_we   (cpu_wr_en),
    .cpu_wd   (cpu_wr_data),
    .cfg_we   (cfg_wr_en),
    .cfg_wd   (cfg_wr_data),
    .clr_flag (clr_flag)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    pcs_sticky_bit #(
      .TIE_ZERO (TARGET_ONLY && (g == IDX_TABORT_SENT))
    ) u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_flag[g]),
      .clr_i (clr_flag[g]),
      .q_o   (flag_q[g])
    );
  end

  always_comb begin
    status = CONST_W;
    for (int g = 0; g < NUM_EV; g++) begin
      status[EV_POS[g]] = flag_q[g];
    end
  end

  assign cpu_rd_data = status;
  assign cfg_rd_data = status;

  p_ports_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_data == cfg_rd_data);
  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & RSVD_MASK) == '0);
  p_perr_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_perr_detect |=> cpu_rd_data[15]);
  p_mdperr_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!parity_resp_en && !cpu_rd_data[8]) |=> !cpu_rd_data[8]);
  p_serr_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_serr_sent |=> cfg_rd_data[14]);
endmodule

// File: tb/pci_cfg_status_bench.sv
module pci_cfg_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pen = 1'b0;
  logic [5:0] ev = '0;
  logic cwe = 1'b0, fwe = 1'b0;
  logic [15:0] cwd = '0, fwd = '0;
  logic [15:0] c1, f1, c2, f2;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [15:0] K1 = 16'h0290; // devsel 01, fb2b 1, 66 0, caplist 1
  localparam logic [15:0] K2 = 16'h0420; // devsel 10, fb2b 0, 66 1, caplist 0
  localparam logic [15:0] EVM = 16'hF900;
  logic [15:0] exp_ev = '0;

  always #10 clk = ~clk;

  pci_cfg_status u_pci_cfg_status (
    .clk(clk), .rst_n(rst_n), .parity_resp_en(pen),
    .ev_perr_detect(ev[0]), .ev_serr_sent(ev[1]), .ev_mabort_rcvd(ev[2]),
    .ev_tabort_rcvd(ev[3]), .ev_tabort_sent(ev[4]), .ev_master_dperr(ev[5]),
    .cpu_wr_en(cwe), .cpu_wr_data(cwd), .cpu_rd_data(c1),
    .cfg_wr_en(fwe), .cfg_wr_data(fwd), .cfg_rd_data(f1));

  pci_cfg_status #(.DEVSEL_TIMING(2'b10), .FAST_B2B(1'b0), .CAP_66MHZ(1'b1),
                   .CAP_LIST(1'b0), .TARGET_ONLY(1'b1)) u_pci_cfg_status_tgt (
    .clk(clk), .rst_n(rst_n), .parity_resp_en(pen),
    .ev_perr_detect(ev[0]), .ev_serr_sent(ev[1]), .ev_mabort_rcvd(ev[2]),
    .ev_tabort_rcvd(ev[3]), .ev_tabort_sent(ev[4]), .ev_master_dperr(ev[5]),
    .cpu_wr_en(cwe), .cpu_wr_data(cwd), .cpu_rd_data(c2),
    .cfg_wr_en(fwe), .cfg_wr_data(fwd), .cfg_rd_data(f2));

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] set_word(input logic [5:0] s, input logic p);
    logic [15:0] w;
    w = '0;
    w[15] = s[0]; w[14] = s[1]; w[13] = s[2];
    w[12] = s[3]; w[11] = s[4]; w[8] = s[5] & p;
    return w;
  endfunction

  task automatic check_all(input string tag);
    check(c1, exp_ev | K1, tag);
    check(f1, c1, {tag, " R2"});
    check(c2, (exp_ev & ~16'h0800) | K2, {tag, " R11"});
    check(f2, c2, {tag, " R2"});
  endtask

  task automatic step(input logic [5:0] s, input logic p,
                      input logic ce, input logic [15:0] cd,
                      input logic fe, input logic [15:0] fd, input string tag);
    logic [15:0] clr;
    ev = s; pen = p; cwe = ce; cwd = cd; fwe = fe; fwd = fd;
    @(posedge clk);
    #1;
    clr = (ce ? cd : 16'h0) | (fe ? fd : 16'h0);
    exp_ev = ((exp_ev & ~clr) | set_word(s, p)) & EVM;
    check_all(tag);
    ev = '0; cwe = 1'b0; fwe = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(c1, K1, "R1 in reset");
    check(c2, K2, "R1 in reset tgt");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after reset");
    check(c1 & 16'h004F, 16'h0, "R5 reserved");
    check(c1 & ~EVM, K1, "R5 constants");

    // R4: writing all ones to an empty word sets nothing
    step(6'h00, 1'b1, 1'b1, 16'hFFFF, 1'b1, 16'hFFFF, "R4 all-ones write");
    // R6: parity flag with response disabled
    step(6'h01, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R6 perr pen=0");
    // R7: master data parity gated
    step(6'h20, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R7 mdperr pen=0");
    check(c1[8], 1'b0, "R7 bit8 stays 0");
    step(6'h20, 1'b1, 1'b0, 16'h0, 1'b0, 16'h0, "R7 mdperr pen=1");
    check(c1[8], 1'b1, "R7 bit8 set");
    // R8 and R11
    step(6'h1E, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R8 set group");
    step(6'h00, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, "R8 hold");
    check(c2[11], 1'b0, "R11 tied bit");
    // R3: 16'h4000 clears bit 14 only
    step(6'h00, 1'b0, 1'b1, 16'h4000, 1'b0, 16'h0, "R3 clear bit14");
    check(c1, 16'hB900 | K1, "R3 only bit14 gone");
    // R9: set and clear on the same flag
    step(6'h02, 1'b0, 1'b1, 16'h4000, 1'b1, 16'h4000, "R9 set beats clear");
    check(c1[14], 1'b1, "R9 bit14 kept");
    // R10: two ports, disjoint masks
    step(6'h00, 1'b0, 1'b1, 16'h8000, 1'b1, 16'h0100, "R10 OR of masks");
    check(c1 & EVM, 16'h7800, "R10 result");

    // Sweep: all strobe sets, pen, port modes
    for (int s = 0; s < 64; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int m = 0; m < 4; m++) begin
          logic [15:0] ma, mb;
          ma = 16'((s * 16'h2F1B) ^ (p * 16'h0503) ^ (m * 16'h9247));
          mb = 16'((s * 16'h1D35) ^ (m * 16'h6A11));
          step(6'(s), p[0], 1'b0, 16'h0, 1'b0, 16'h0, "R8 sweep set");
          step(6'(s >> (m + 1)), p[0], m[0], ma, m[1], mb, "R3 R9 R10 sweep");
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule